// File: doc/BRIEF.md
# Eight-Function Byte ALU

This block is the purely combinational arithmetic and logic unit of a small 8-bit processor datapath. It accepts two byte operands and a 3-bit function code. It returns a byte result together with a flag that is high when that result is all zeros. The branch logic outside the block uses this flag to choose between equal and not-equal outcomes.

The block has no subtract function of its own. To subtract, the surrounding datapath negates the second operand in two's complement and then requests the add function. Shift and rotate functions move the first operand by the amount held in the low bits of the second operand. A separate direction pin selects a left or right logical shift.

Top module: `alu8`

## Requirements
- R1: Function code 000 drives `b_in` unchanged onto `result`.
- R2: Function code 001 drives `(a_in + b_in) mod 256` onto `result`.
- R3: Function code 010 drives the bitwise AND of `a_in` and `b_in`.
- R4: Function code 011 drives the bitwise OR of `a_in` and `b_in`.
- R5: Function code 100 drives the low 8 bits of the unsigned product `a_in * b_in`.
- R6: Function code 101 with `shift_left` = 1 shifts `a_in` left by `b_in[2:0]` places and fills the vacated low bits with zeros.
- R7: Function code 101 with `shift_left` = 0 shifts `a_in` right by `b_in[2:0]` places and fills the vacated high bits with zeros.
- R8: Function code 110 shifts `a_in` right by `b_in[2:0]` places and fills the vacated high bits with copies of `a_in[7]`.
- R9: Function code 111 rotates `a_in` right by `b_in[2:0]` places. Bits that leave at bit 0 re-enter at bit 7.
- R10: For every function code, `is_zero` is 1 exactly when `result` is 8'h00.
- R11: With function code 001 and `b_in` set to the two's complement of a value c, `result` equals `(a_in - c) mod 256`, and `is_zero` is 1 exactly when `a_in == c`.
- R12: `shift_left` has no effect on `result` or `is_zero` for any function code other than 101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 8 | First operand; the value that shift and rotate functions move |
| b_in | input | 8 | Second operand; bits [2:0] give the shift or rotate amount |
| op_sel | input | 3 | Function code |
| shift_left | input | 1 | Direction for the logical shift function: 1 selects left, 0 selects right |
| result | output | 8 | Function output |
| is_zero | output | 1 | High when `result` is all zeros |

## Verification
Every function code is driven with every pair of byte operands, under both values of the direction pin. The full sweep covers several cases that separate the functions:
- carries out of bit 7 in the sum and products wider than a byte, which show wraparound and truncation;
- operands with bit 7 set, which separate the arithmetic right shift from the logical one;
- every shift amount from 0 to 7, which separates rotation from shifting.

Because the high bits of `b_in` are swept, the sweep also shows that they do not change the shift amount. Repeating each vector with the direction pin flipped shows whether that pin disturbs any other function. Subtraction is checked by negating c in the bench and comparing the flag against operand equality.

// File: rtl/alu8.sv
module alu8 #(
  parameter int W = 8
) (
  input  logic [W-1:0]         a_in,
  input  logic [W-1:0]         b_in,
  input  logic [2:0]           op_sel,
  input  logic                 shift_left,
  output logic [W-1:0]         result,
  output logic                 is_zero
);
  localparam int SW = $clog2(W);
  localparam int PW = 2 * W;

  logic [SW-1:0] amt;
  logic [PW-1:0] prod;
  logic [W-1:0]  sh_log, sh_ari, rot;

  assign amt    = b_in[SW-1:0];
  assign prod   = a_in * b_in;
  assign sh_log = shift_left ? (a_in << amt) : (a_in >> amt);
  assign sh_ari = W'($signed(a_in) >>> amt);
  assign rot    = W'({a_in, a_in} >> amt);

  always_comb begin
    unique case (op_sel)
      3'b000:  result = b_in;
      3'b001:  result = a_in + b_in;
      3'b010:  result = a_in & b_in;
      3'b011:  result = a_in | b_in;
      3'b100:  result = prod[W-1:0];
      3'b101:  result = sh_log;
      3'b110:  result = sh_ari;
      default: result = rot;
    endcase
  end

  assign is_zero = ~|result;

  always_comb begin
    if (op_sel == 3'b001)
      a_r2_sum_inverts: assert (W'(result - b_in) == a_in);
    if (op_sel == 3'b010)
      a_r3_and_subset: assert (((result & ~a_in) | (result & ~b_in)) == '0);
    if (op_sel == 3'b011)
      a_r4_or_superset: assert ((result & a_in) == a_in && (result & b_in) == b_in);
    if (op_sel == 3'b110)
      a_r8_sign_kept: assert (result[W-1] == a_in[W-1]);
    if (op_sel == 3'b111)
      a_r9_rot_undo: assert (W'({result, result} >> (W - int'(amt))) == a_in);
    a_r10_flag_only_on_zero: assert (!is_zero || result == '0);
    a_r10_zero_sets_flag: assert (result != '0 || is_zero);
  end
endmodule

// File: tb/test_alu8.sv
`timescale 1ns/1ps
module test_alu8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] a_in, b_in;
  logic [2:0] op_sel;
  logic       shift_left;
  logic [7:0] result;
  logic       is_zero;
  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  alu8 i_alu8 (
    .a_in(a_in), .b_in(b_in), .op_sel(op_sel), .shift_left(shift_left),
    .result(result), .is_zero(is_zero)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s op=%0d dir=%0d a=%0d b=%0d actual=%0d expected=%0d",
               req, op_sel, shift_left, a_in, b_in, act, exp);
    end
  endtask

  function automatic int model(input int op, input int d, input int a, input int b);
    int n = b % 8;
    int p = 1 << n;
    case (op)
      0: return b;
      1: return (a + b) % 256;
      2: return a & b;
      3: return a | b;
      4: return (a * b) % 256;
      5: return d ? (a * p) % 256 : a / p;
      6: return a / p + ((a >= 128) ? (256 - 256 / p) : 0);
      default: return (a / p + a * (256 / p)) % 256;
    endcase
  endfunction

  function automatic string tag(input int op, input int d);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return d ? "R6" : "R7";
      6: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    a_in = 8'd0; b_in = 8'd0; op_sel = 3'd0; shift_left = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R10", int'(is_zero), 1);
    chk("R1", int'(result), 0);

    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++) begin
          int e0, r0, z0;
          op_sel = op[2:0]; a_in = a[7:0]; b_in = b[7:0];
          for (int d = 0; d < 2; d++) begin
            int e;
            shift_left = d[0];
            #1;
            e = model(op, d, a, b);
            chk(tag(op, d), int'(result), e);
            chk("R10", int'(is_zero), (e == 0) ? 1 : 0);
            if (d == 0) begin
              r0 = int'(result);
              z0 = int'(is_zero);
            end else if (op != 5) begin
              chk("R12", int'(result), r0);
              chk("R12", int'(is_zero), z0);
            end
            e0 = e;
          end
          if (e0 < 0) $display("unreachable");
        end

    op_sel = 3'b001; shift_left = 1'b0;
    for (int a = 0; a < 256; a++)
      for (int c = 0; c < 256; c++) begin
        a_in = a[7:0];
        b_in = 8'((256 - c) % 256);
        #1;
        chk("R11", int'(result), (a - c + 256) % 256);
        chk("R11", int'(is_zero), (a == c) ? 1 : 0);
      end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule